// File: doc/BRIEF.md
# Queue Port Messaging Unit

This unit connects a host-side register slave to an embedded I/O processor. The host sees a small window of 32-bit registers. Two of them are inbound message registers, where the host writes commands. Two are outbound message registers, where the processor posts replies. There is also a doorbell, a status and mask pair for each direction, and two queue ports. The processor sees the same state through plain push and pop strobes, with no address decode on its side.

Each queue port is backed by a pair of FIFOs, and a read and a write to the same port address do different things:

- Inbound port, read: pops a free packet offset that the processor has stocked.
- Inbound port, write: posts a request.
- Outbound port, read: pops a completion.
- Outbound port, write: hands a locally allocated packet back to the processor.

A posted word with bit 31 set refers to a packet in host memory. Its low 31 bits hold the packet's bus address shifted right by five, because such packets sit on 32-byte boundaries.

A non-queued command is written to inbound message 0. It counts as finished when the processor writes the same value to outbound message 0.

Top module: `qport_msg_unit`

## Requirements
- R1: Register offsets (8-bit byte address): 0x10/0x14 inbound message 0/1, 0x18/0x1C outbound message 0/1, 0x20 doorbell, 0x24 inbound status, 0x28 inbound mask, 0x30 outbound status, 0x34 outbound mask, 0x40 inbound queue port, 0x44 outbound queue port. A read returns its data on `hst_rdata` with `hst_rvalid` high in the cycle after `hst_rd_en`. An unmapped offset reads as zero. Inbound messages also appear on `iop_imsg0`/`iop_imsg1`.
- R2: A read of 0x40 pops the oldest free offset pushed by the processor. If the free list is empty, it returns 0xFFFFFFFF and changes nothing.
- R3: A write to 0x40 appends the word to the posted list, which the processor drains oldest first. `iop_post_host` equals bit 31 of the word at the head of the list. `iop_post_addr` is bits 30:0 shifted left by 5 when bit 31 is set, and bits 30:0 zero-extended otherwise.
- R4: A read of 0x44 pops the oldest completion. If the completion list is empty, it returns 0xFFFFFFFF.
- R5: A write to 0x44 appends the word to the returned list, which the processor drains oldest first.
- R6: Each list holds FIFO_DEPTH words. A push into a full list is dropped, and the stored words stay unchanged.
- R7: Outbound status (0x30, 4 bits) works as follows:
  - bit 0 is set when the processor writes outbound message 0;
  - bit 1 is set when the processor writes outbound message 1;
  - bit 3 is set when a completion push is accepted;
  - bit 2 always reads 0;
  - the host clears a bit by writing 1 to it, and a set in the same cycle wins.
- R8: `host_irq` is high while any outbound status bit is 1 and its bit in the outbound mask (0x34) is 0. The mask resets to 0xF.
- R9: A write to 0x20 ORs the word into the pending doorbell, shown on `iop_doorbell`. The processor clears bits through `iop_db_clr`, 1 = clear, and a host set in the same cycle wins.
- R10: Inbound status (0x24) bit 0 is set by a host write of 0x10, and bit 1 by a host write of 0x14. Both are cleared by `iop_istat_clr`. Bit 2 reads 1 while the doorbell is nonzero. `iop_irq` is high while any of these bits is 1 with its inbound mask (0x28, 3 bits, reset 0x7) bit at 0.
- R11: `hst_cmd_done` rises when the processor writes outbound message 0 with the value held in inbound message 0, but only after a host write to 0x10. A mismatching value leaves it low, and the next host write to 0x10 clears it.
- R12: After reset, all message, doorbell and status registers are zero, both masks are all ones, every list is empty, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_rd_en | input | 1 | Host register read strobe |
| hst_addr | input | 8 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data, valid the cycle after the read |
| hst_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Interrupt to the host |
| hst_cmd_done | output | 1 | Non-queued command acknowledged |
| iop_irq | output | 1 | Interrupt to the processor |
| iop_imsg0 | output | 32 | Inbound message 0 |
| iop_imsg1 | output | 32 | Inbound message 1 |
| iop_doorbell | output | 32 | Pending doorbell bits |
| iop_istat_clr | input | 2 | Clear inbound status bits 1:0 |
| iop_db_clr | input | 32 | Clear doorbell bits |
| iop_omsg_we | input | 2 | Write outbound message 1:0 |
| iop_omsg_wdata | input | 32 | Outbound message data |
| iop_free_push | input | 1 | Push a free packet offset |
| iop_free_data | input | 32 | Free packet offset |
| iop_free_full | output | 1 | Free list full |
| iop_post_pop | input | 1 | Pop a posted request |
| iop_post_valid | output | 1 | Posted list not empty |
| iop_post_data | output | 32 | Head posted word |
| iop_post_host | output | 1 | Head request lives in host memory |
| iop_post_addr | output | 36 | Head request address or offset |
| iop_cpl_push | input | 1 | Push a completion |
| iop_cpl_data | input | 32 | Completion word |
| iop_cpl_full | output | 1 | Completion list full |
| iop_ret_pop | input | 1 | Pop a returned packet |
| iop_ret_valid | output | 1 | Returned list not empty |
| iop_ret_data | output | 32 | Head returned packet offset |

## Verification
Some properties are asserted on every cycle:
- no list overflows, and a full list holds still under a push;
- a pop of an empty list leaves it empty;
- every accepted completion sets outbound status bit 3;
- doorbell bits never drop without a processor clear;
- `hst_cmd_done` only rises on an outbound message 0 write;
- every read gets its valid a cycle later.

Some behaviours depend on data and ordering, so only the bench's reference model can show them. These are the oldest-first order of each list, the 0xFFFFFFFF answer from an empty port, and the bit 31 host tag with its shifted address. They also include write-1-to-clear racing a set, mask gating of both interrupts, and a mismatched command echo.

// File: rtl/qpmu_pkg.sv
package qpmu_pkg;

    localparam int unsigned REG_AW  = 8;
    localparam int unsigned WORD_W  = 32;

    // Register byte offsets
    localparam logic [REG_AW-1:0] OFS_IMSG0 = 8'h10;
    localparam logic [REG_AW-1:0] OFS_IMSG1 = 8'h14;
    localparam logic [REG_AW-1:0] OFS_OMSG0 = 8'h18;
    localparam logic [REG_AW-1:0] OFS_OMSG1 = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_DBELL = 8'h20;
    localparam logic [REG_AW-1:0] OFS_ISTAT = 8'h24;
    localparam logic [REG_AW-1:0] OFS_IMASK = 8'h28;
    localparam logic [REG_AW-1:0] OFS_OSTAT = 8'h30;
    localparam logic [REG_AW-1:0] OFS_OMASK = 8'h34;
    localparam logic [REG_AW-1:0] OFS_QIN   = 8'h40;
    localparam logic [REG_AW-1:0] OFS_QOUT  = 8'h44;

    localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

    // Queue indices
    localparam int Q_FREE = 0;
    localparam int Q_POST = 1;
    localparam int Q_CPL  = 2;
    localparam int Q_RET  = 3;
    localparam int NUM_Q  = 4;

    localparam int unsigned ISTAT_W = 3;
    localparam int unsigned OSTAT_W = 4;
    localparam logic [OSTAT_W-1:0] OSTAT_LIVE = 4'b1011;

    typedef struct packed {
        logic [WORD_W-1:0]  imsg0;
        logic [WORD_W-1:0]  imsg1;
        logic [WORD_W-1:0]  omsg0;
        logic [WORD_W-1:0]  omsg1;
        logic [WORD_W-1:0]  dbell;
        logic [1:0]         istat;
        logic [ISTAT_W-1:0] imask;
        logic [OSTAT_W-1:0] ostat;
        logic [OSTAT_W-1:0] omask;
        logic               cmd_wait;
        logic               cmd_done;
        logic [WORD_W-1:0]  rdata;
        logic               rvalid;
    } regs_t;

endpackage

// File: rtl/qpmu_fifo.sv
module qpmu_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [PW:0] wptr;
        logic [PW:0] rptr;
    } fptr_t;

    fptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  count;
    logic         push_ok, pop_ok;

    assign count = q.wptr - q.rptr;
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign head  = mem[q.rptr[PW-1:0]];

    always_comb begin
        d       = q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) d.wptr = q.wptr + (PW+1)'(1);
        if (pop_ok)  d.rptr = q.rptr + (PW+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wptr[PW-1:0]] <= din;
    end

    // R6: occupancy never exceeds the depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R6: a push into a full list without a pop leaves it untouched
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(q.wptr)));

    // R2: popping an empty list keeps it empty
    p_empty_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/qpmu_regs.sv
module qpmu_regs
    import qpmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_wr_en,
    input  logic                hst_rd_en,
    input  logic [REG_AW-1:0]   hst_addr,
    input  logic [WORD_W-1:0]   hst_wdata,
    output logic [WORD_W-1:0]   hst_rdata,
    output logic                hst_rvalid,
    output logic                host_irq,
    output logic                hst_cmd_done,
    output logic                iop_irq,
    output logic [WORD_W-1:0]   iop_imsg0,
    output logic [WORD_W-1:0]   iop_imsg1,
    output logic [WORD_W-1:0]   iop_doorbell,
    input  logic [1:0]          iop_istat_clr,
    input  logic [WORD_W-1:0]   iop_db_clr,
    input  logic [1:0]          iop_omsg_we,
    input  logic [WORD_W-1:0]   iop_omsg_wdata,
    input  logic                iop_cpl_push,
    input  logic [WORD_W-1:0]   free_head,
    input  logic                free_empty,
    input  logic [WORD_W-1:0]   cpl_head,
    input  logic                cpl_empty,
    input  logic                cpl_full,
    input  logic                post_full,
    input  logic                ret_full,
    output logic                free_pop,
    output logic                post_push,
    output logic                cpl_pop,
    output logic                ret_push
);
    regs_t q, d;
    logic  cpl_accept;
    logic  wr_hit_imsg0;
    logic [ISTAT_W-1:0] istat_view;

    assign cpl_accept   = iop_cpl_push && !cpl_full;
    assign wr_hit_imsg0 = hst_wr_en && (hst_addr == OFS_IMSG0);
    assign istat_view   = {(q.dbell != '0), q.istat};

    assign free_pop  = hst_rd_en && (hst_addr == OFS_QIN)  && !free_empty;
    assign cpl_pop   = hst_rd_en && (hst_addr == OFS_QOUT) && !cpl_empty;
    assign post_push = hst_wr_en && (hst_addr == OFS_QIN)  && !post_full;
    assign ret_push  = hst_wr_en && (hst_addr == OFS_QOUT) && !ret_full;

    always_comb begin
        d = q;

        // Non-queued command echo: match against the held inbound message 0
        if (iop_omsg_we[0] && q.cmd_wait && (iop_omsg_wdata == q.imsg0)) begin
            d.cmd_done = 1'b1;
            d.cmd_wait = 1'b0;
        end

        // Processor-side clears
        d.istat = q.istat & ~iop_istat_clr;
        d.dbell = q.dbell & ~iop_db_clr;

        // Host write-one-to-clear on outbound status, sets below win
        if (hst_wr_en && (hst_addr == OFS_OSTAT))
            d.ostat = q.ostat & ~hst_wdata[OSTAT_W-1:0];

        // Processor-side sets
        if (iop_omsg_we[0]) begin
            d.omsg0    = iop_omsg_wdata;
            d.ostat[0] = 1'b1;
        end
        if (iop_omsg_we[1]) begin
            d.omsg1    = iop_omsg_wdata;
            d.ostat[1] = 1'b1;
        end
        if (cpl_accept) d.ostat[3] = 1'b1;
        d.ostat = d.ostat & OSTAT_LIVE;

        // Host writes
        if (hst_wr_en) begin
            unique case (hst_addr)
                OFS_IMSG0: begin
                    d.imsg0    = hst_wdata;
                    d.istat[0] = 1'b1;
                end
                OFS_IMSG1: begin
                    d.imsg1    = hst_wdata;
                    d.istat[1] = 1'b1;
                end
                OFS_DBELL: d.dbell = d.dbell | hst_wdata;
                OFS_IMASK: d.imask = hst_wdata[ISTAT_W-1:0];
                OFS_OMASK: d.omask = hst_wdata[OSTAT_W-1:0];
                default: ;
            endcase
        end
        if (wr_hit_imsg0) begin
            d.cmd_wait = 1'b1;
            d.cmd_done = 1'b0;
        end

        // Host read path, one register stage
        d.rvalid = hst_rd_en;
        d.rdata  = '0;
        if (hst_rd_en) begin
            unique case (hst_addr)
                OFS_IMSG0: d.rdata = q.imsg0;
                OFS_IMSG1: d.rdata = q.imsg1;
                OFS_OMSG0: d.rdata = q.omsg0;
                OFS_OMSG1: d.rdata = q.omsg1;
                OFS_DBELL: d.rdata = q.dbell;
                OFS_ISTAT: d.rdata = WORD_W'(istat_view);
                OFS_IMASK: d.rdata = WORD_W'(q.imask);
                OFS_OSTAT: d.rdata = WORD_W'(q.ostat);
                OFS_OMASK: d.rdata = WORD_W'(q.omask);
                OFS_QIN:   d.rdata = free_empty ? EMPTY_WORD : free_head;
                OFS_QOUT:  d.rdata = cpl_empty  ? EMPTY_WORD : cpl_head;
                default:   d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.imask <= '1;
            q.omask <= '1;
        end else begin
            q <= d;
        end
    end

    assign hst_rdata    = q.rdata;
    assign hst_rvalid   = q.rvalid;
    assign hst_cmd_done = q.cmd_done;
    assign iop_imsg0    = q.imsg0;
    assign iop_imsg1    = q.imsg1;
    assign iop_doorbell = q.dbell;
    assign host_irq     = |(q.ostat & ~q.omask);
    assign iop_irq      = |(istat_view & ~q.imask);

    // R1: every read strobe yields valid data one cycle later
    p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hst_rd_en |=> hst_rvalid);

    // R7: an accepted completion always leaves status bit 3 set
    p_cpl_sets_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iop_cpl_push && !cpl_full) |=> q.ostat[3]);

    // R8: a fully set outbound mask keeps the host interrupt low
    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && (hst_addr == OFS_OMASK) && (hst_wdata[OSTAT_W-1:0] == '1))
        |=> !host_irq);

    // R9: doorbell bits survive any cycle without a processor clear
    p_db_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iop_db_clr == '0) |=> ((q.dbell & $past(q.dbell)) == $past(q.dbell)));

    // R11: command completion appears only on an outbound message 0 write
    p_cmd_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cmd_done) |-> $past(iop_omsg_we[0]));

endmodule

// File: rtl/qport_msg_unit.sv
module qport_msg_unit
    import qpmu_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 4,
    parameter int unsigned ALIGN_SHIFT = 5,
    localparam int unsigned HOST_AW    = WORD_W - 1 + ALIGN_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_wr_en,
    input  logic                hst_rd_en,
    input  logic [REG_AW-1:0]   hst_addr,
    input  logic [WORD_W-1:0]   hst_wdata,
    output logic [WORD_W-1:0]   hst_rdata,
    output logic                hst_rvalid,
    output logic                host_irq,
    output logic                hst_cmd_done,
    output logic                iop_irq,
    output logic [WORD_W-1:0]   iop_imsg0,
    output logic [WORD_W-1:0]   iop_imsg1,
    output logic [WORD_W-1:0]   iop_doorbell,
    input  logic [1:0]          iop_istat_clr,
    input  logic [WORD_W-1:0]   iop_db_clr,
    input  logic [1:0]          iop_omsg_we,
    input  logic [WORD_W-1:0]   iop_omsg_wdata,
    input  logic                iop_free_push,
    input  logic [WORD_W-1:0]   iop_free_data,
    output logic                iop_free_full,
    input  logic                iop_post_pop,
    output logic                iop_post_valid,
    output logic [WORD_W-1:0]   iop_post_data,
    output logic                iop_post_host,
    output logic [HOST_AW-1:0]  iop_post_addr,
    input  logic                iop_cpl_push,
    input  logic [WORD_W-1:0]   iop_cpl_data,
    output logic                iop_cpl_full,
    input  logic                iop_ret_pop,
    output logic                iop_ret_valid,
    output logic [WORD_W-1:0]   iop_ret_data
);
    logic [NUM_Q-1:0]  f_push, f_pop, f_empty, f_full;
    logic [WORD_W-1:0] f_din  [NUM_Q];
    logic [WORD_W-1:0] f_head [NUM_Q];

    logic host_free_pop, host_post_push, host_cpl_pop, host_ret_push;

    // Queue wiring: which side pushes and which side pops
    assign f_push[Q_FREE] = iop_free_push;
    assign f_din [Q_FREE] = iop_free_data;
    assign f_pop [Q_FREE] = host_free_pop;

    assign f_push[Q_POST] = host_post_push;
    assign f_din [Q_POST] = hst_wdata;
    assign f_pop [Q_POST] = iop_post_pop;

    assign f_push[Q_CPL]  = iop_cpl_push;
    assign f_din [Q_CPL]  = iop_cpl_data;
    assign f_pop [Q_CPL]  = host_cpl_pop;

    assign f_push[Q_RET]  = host_ret_push;
    assign f_din [Q_RET]  = hst_wdata;
    assign f_pop [Q_RET]  = iop_ret_pop;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        qpmu_fifo #(
            .W     (WORD_W),
            .DEPTH (FIFO_DEPTH)
        ) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (f_push[g]),
            .din   (f_din[g]),
            .pop   (f_pop[g]),
            .head  (f_head[g]),
            .empty (f_empty[g]),
            .full  (f_full[g])
        );
    end

    qpmu_regs i_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .hst_wr_en      (hst_wr_en),
        .hst_rd_en      (hst_rd_en),
        .hst_addr       (hst_addr),
        .hst_wdata      (hst_wdata),
        .hst_rdata      (hst_rdata),
        .hst_rvalid     (hst_rvalid),
        .host_irq       (host_irq),
        .hst_cmd_done   (hst_cmd_done),
        .iop_irq        (iop_irq),
        .iop_imsg0      (iop_imsg0),
        .iop_imsg1      (iop_imsg1),
        .iop_doorbell   (iop_doorbell),
        .iop_istat_clr  (iop_istat_clr),
        .iop_db_clr     (iop_db_clr),
        .iop_omsg_we    (iop_omsg_we),
        .iop_omsg_wdata (iop_omsg_wdata),
        .iop_cpl_push   (iop_cpl_push),
        .free_head      (f_head[Q_FREE]),
        .free_empty     (f_empty[Q_FREE]),
        .cpl_head       (f_head[Q_CPL]),
        .cpl_empty      (f_empty[Q_CPL]),
        .cpl_full       (f_full[Q_CPL]),
        .post_full      (f_full[Q_POST]),
        .ret_full       (f_full[Q_RET]),
        .free_pop       (host_free_pop),
        .post_push      (host_post_push),
        .cpl_pop        (host_cpl_pop),
        .ret_push       (host_ret_push)
    );

    assign iop_free_full  = f_full[Q_FREE];
    assign iop_cpl_full   = f_full[Q_CPL];
    assign iop_post_valid = !f_empty[Q_POST];
    assign iop_post_data  = f_head[Q_POST];
    assign iop_ret_valid  = !f_empty[Q_RET];
    assign iop_ret_data   = f_head[Q_RET];

    // Bit 31 tags a host-memory packet whose bus address was shifted down
    assign iop_post_host  = f_head[Q_POST][WORD_W-1];
    assign iop_post_addr  = iop_post_host
                          ? {f_head[Q_POST][WORD_W-2:0], {ALIGN_SHIFT{1'b0}}}
                          : {{ALIGN_SHIFT{1'b0}}, f_head[Q_POST][WORD_W-2:0]};

    // R3: the host tag follows the posted word's top bit
    p_post_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iop_post_valid && iop_post_host) |-> (iop_post_addr[ALIGN_SHIFT-1:0] == '0));

endmodule

// File: tb/test_qport_msg_unit.sv
module test_qport_msg_unit;
    localparam int DEPTH = 4;
    localparam int HAW   = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr_en = 0, hst_rd_en = 0;
    logic [7:0]  hst_addr = 0;
    logic [31:0] hst_wdata = 0;
    logic [31:0] hst_rdata;
    logic        hst_rvalid, host_irq, hst_cmd_done, iop_irq;
    logic [31:0] iop_imsg0, iop_imsg1, iop_doorbell;
    logic [1:0]  iop_istat_clr = 0;
    logic [31:0] iop_db_clr = 0;
    logic [1:0]  iop_omsg_we = 0;
    logic [31:0] iop_omsg_wdata = 0;
    logic        iop_free_push = 0;
    logic [31:0] iop_free_data = 0;
    logic        iop_free_full;
    logic        iop_post_pop = 0;
    logic        iop_post_valid;
    logic [31:0] iop_post_data;
    logic        iop_post_host;
    logic [HAW-1:0] iop_post_addr;
    logic        iop_cpl_push = 0;
    logic [31:0] iop_cpl_data = 0;
    logic        iop_cpl_full;
    logic        iop_ret_pop = 0;
    logic        iop_ret_valid;
    logic [31:0] iop_ret_data;

    always #10 clk = ~clk;

    qport_msg_unit i_qport_msg_unit (
        .clk(clk), .rst_n(rst_n),
        .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
        .host_irq(host_irq), .hst_cmd_done(hst_cmd_done), .iop_irq(iop_irq),
        .iop_imsg0(iop_imsg0), .iop_imsg1(iop_imsg1), .iop_doorbell(iop_doorbell),
        .iop_istat_clr(iop_istat_clr), .iop_db_clr(iop_db_clr),
        .iop_omsg_we(iop_omsg_we), .iop_omsg_wdata(iop_omsg_wdata),
        .iop_free_push(iop_free_push), .iop_free_data(iop_free_data),
        .iop_free_full(iop_free_full),
        .iop_post_pop(iop_post_pop), .iop_post_valid(iop_post_valid),
        .iop_post_data(iop_post_data), .iop_post_host(iop_post_host),
        .iop_post_addr(iop_post_addr),
        .iop_cpl_push(iop_cpl_push), .iop_cpl_data(iop_cpl_data),
        .iop_cpl_full(iop_cpl_full),
        .iop_ret_pop(iop_ret_pop), .iop_ret_valid(iop_ret_valid),
        .iop_ret_data(iop_ret_data)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R12";

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] free_q[$], post_q[$], cpl_q[$], ret_q[$];
    logic [31:0] m_imsg0, m_imsg1, m_omsg0, m_omsg1, m_db, m_rdata, nx;
    logic [1:0]  m_istat;
    logic [2:0]  m_imask;
    logic [3:0]  m_ostat, m_omask;
    logic        m_wait, m_done, m_rvalid;
    bit fr_pop, fr_push, po_pop, po_push, cp_pop, cp_push, rt_pop, rt_push;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_q.delete(); post_q.delete(); cpl_q.delete(); ret_q.delete();
            m_imsg0 = 0; m_imsg1 = 0; m_omsg0 = 0; m_omsg1 = 0; m_db = 0;
            m_istat = 0; m_imask = 3'h7; m_ostat = 0; m_omask = 4'hF;
            m_wait = 0; m_done = 0; m_rdata = 0; m_rvalid = 0;
        end else begin
            nx = 0;
            if (hst_rd_en) begin
                case (hst_addr)
                    8'h10: nx = m_imsg0;
                    8'h14: nx = m_imsg1;
                    8'h18: nx = m_omsg0;
                    8'h1C: nx = m_omsg1;
                    8'h20: nx = m_db;
                    8'h24: nx = {29'b0, (m_db != 0), m_istat};
                    8'h28: nx = {29'b0, m_imask};
                    8'h30: nx = {28'b0, m_ostat};
                    8'h34: nx = {28'b0, m_omask};
                    8'h40: nx = (free_q.size() > 0) ? free_q[0] : 32'hFFFF_FFFF;
                    8'h44: nx = (cpl_q.size() > 0) ? cpl_q[0] : 32'hFFFF_FFFF;
                    default: nx = 0;
                endcase
            end
            fr_pop  = hst_rd_en && hst_addr == 8'h40 && free_q.size() > 0;
            fr_push = iop_free_push && free_q.size() < DEPTH;
            po_pop  = iop_post_pop && post_q.size() > 0;
            po_push = hst_wr_en && hst_addr == 8'h40 && post_q.size() < DEPTH;
            cp_pop  = hst_rd_en && hst_addr == 8'h44 && cpl_q.size() > 0;
            cp_push = iop_cpl_push && cpl_q.size() < DEPTH;
            rt_pop  = iop_ret_pop && ret_q.size() > 0;
            rt_push = hst_wr_en && hst_addr == 8'h44 && ret_q.size() < DEPTH;
            if (fr_pop) void'(free_q.pop_front());
            if (po_pop) void'(post_q.pop_front());
            if (cp_pop) void'(cpl_q.pop_front());
            if (rt_pop) void'(ret_q.pop_front());
            if (fr_push) free_q.push_back(iop_free_data);
            if (po_push) post_q.push_back(hst_wdata);
            if (cp_push) cpl_q.push_back(iop_cpl_data);
            if (rt_push) ret_q.push_back(hst_wdata);

            if (iop_omsg_we[0] && m_wait && iop_omsg_wdata == m_imsg0) begin
                m_done = 1; m_wait = 0;
            end
            m_istat = m_istat & ~iop_istat_clr;
            m_db    = m_db & ~iop_db_clr;
            if (hst_wr_en && hst_addr == 8'h30) m_ostat = m_ostat & ~hst_wdata[3:0];
            if (iop_omsg_we[0]) begin m_omsg0 = iop_omsg_wdata; m_ostat[0] = 1; end
            if (iop_omsg_we[1]) begin m_omsg1 = iop_omsg_wdata; m_ostat[1] = 1; end
            if (cp_push) m_ostat[3] = 1;
            if (hst_wr_en) begin
                case (hst_addr)
                    8'h10: begin m_imsg0 = hst_wdata; m_istat[0] = 1; m_wait = 1; m_done = 0; end
                    8'h14: begin m_imsg1 = hst_wdata; m_istat[1] = 1; end
                    8'h20: m_db = m_db | hst_wdata;
                    8'h28: m_imask = hst_wdata[2:0];
                    8'h34: m_omask = hst_wdata[3:0];
                    default: ;
                endcase
            end
            m_rdata  = nx;
            m_rvalid = hst_rd_en;
        end
    end

    task automatic compare_all();
        logic [HAW-1:0] ea;
        chk({cur_req, " rvalid"}, 64'(hst_rvalid), 64'(m_rvalid));
        chk({cur_req, " rdata"},  64'(hst_rdata),  64'(m_rdata));
        chk("R8 host_irq", 64'(host_irq), 64'(|(m_ostat & ~m_omask)));
        chk("R10 iop_irq", 64'(iop_irq), 64'(|({(m_db != 0), m_istat} & ~m_imask)));
        chk("R1 imsg0", 64'(iop_imsg0), 64'(m_imsg0));
        chk("R1 imsg1", 64'(iop_imsg1), 64'(m_imsg1));
        chk("R9 doorbell", 64'(iop_doorbell), 64'(m_db));
        chk("R11 cmd_done", 64'(hst_cmd_done), 64'(m_done));
        chk("R6 free_full", 64'(iop_free_full), 64'(free_q.size() == DEPTH));
        chk("R6 cpl_full", 64'(iop_cpl_full), 64'(cpl_q.size() == DEPTH));
        chk("R3 post_valid", 64'(iop_post_valid), 64'(post_q.size() > 0));
        chk("R5 ret_valid", 64'(iop_ret_valid), 64'(ret_q.size() > 0));
        if (post_q.size() > 0) begin
            ea = post_q[0][31] ? {post_q[0][30:0], 5'b0} : {5'b0, post_q[0][30:0]};
            chk("R3 post_data", 64'(iop_post_data), 64'(post_q[0]));
            chk("R3 post_host", 64'(iop_post_host), 64'(post_q[0][31]));
            chk("R3 post_addr", 64'(iop_post_addr), 64'(ea));
        end
        if (ret_q.size() > 0)
            chk("R5 ret_data", 64'(iop_ret_data), 64'(ret_q[0]));
    endtask

    task automatic step();
        @(posedge clk);
        #5;
        compare_all();
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] v);
        hst_wr_en = 1; hst_addr = a; hst_wdata = v;
        step();
        hst_wr_en = 0;
    endtask

    task automatic hrd(input logic [7:0] a);
        hst_rd_en = 1; hst_addr = a;
        step();
        hst_rd_en = 0;
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1;
        step();
        // R12: reset state
        cur_req = "R12";
        chk("R12 host_irq", 64'(host_irq), 0);
        chk("R12 iop_irq", 64'(iop_irq), 0);
        hrd(8'h28); chk("R12 imask reset", 64'(hst_rdata), 64'h7);
        hrd(8'h34); chk("R12 omask reset", 64'(hst_rdata), 64'hF);
        hrd(8'h44); chk("R12 cpl empty", 64'(hst_rdata), 64'hFFFF_FFFF);

        // R1 + R10: message registers and inbound status
        cur_req = "R1";
        hwr(8'h10, 32'hCAFE_0001);
        hwr(8'h14, 32'h0BAD_F00D);
        hrd(8'h14); chk("R1 imsg1 read", 64'(hst_rdata), 64'h0BAD_F00D);
        hrd(8'h3C); chk("R1 unmapped", 64'(hst_rdata), 0);
        cur_req = "R10";
        hrd(8'h24); chk("R10 istat", 64'(hst_rdata), 64'h3);
        hwr(8'h28, 32'h0);
        chk("R10 iop_irq on", 64'(iop_irq), 1);
        iop_istat_clr = 2'b01; step(); iop_istat_clr = 0;
        hrd(8'h24); chk("R10 istat after clear", 64'(hst_rdata), 64'h2);
        iop_istat_clr = 2'b10; step(); iop_istat_clr = 0;
        chk("R10 iop_irq off", 64'(iop_irq), 0);

        // R9: doorbell OR and processor clear, set wins
        cur_req = "R9";
        hwr(8'h20, 32'h5);
        hwr(8'h20, 32'h30);
        chk("R9 doorbell or", 64'(iop_doorbell), 64'h35);
        iop_db_clr = 32'h4; hst_wr_en = 1; hst_addr = 8'h20; hst_wdata = 32'h4;
        step(); hst_wr_en = 0; iop_db_clr = 0;
        chk("R9 set beats clear", 64'(iop_doorbell), 64'h35);
        iop_db_clr = 32'hFFFF_FFFF; step(); iop_db_clr = 0;
        chk("R9 cleared", 64'(iop_doorbell), 0);

        // R2: free list order and empty read
        cur_req = "R2";
        iop_free_push = 1; iop_free_data = 32'h100; step();
        iop_free_data = 32'h200; step(); iop_free_push = 0;
        hrd(8'h40); chk("R2 first", 64'(hst_rdata), 64'h100);
        hrd(8'h40); chk("R2 second", 64'(hst_rdata), 64'h200);
        hrd(8'h40); chk("R2 empty", 64'(hst_rdata), 64'hFFFF_FFFF);

        // R3 + R6: posting, host tag, overflow
        cur_req = "R3";
        hwr(8'h40, 32'h0000_1240);
        hwr(8'h40, 32'h8000_0000 | (32'h00AB_CDE0 >> 5));
        iop_post_pop = 1; step(); iop_post_pop = 0;
        chk("R3 host tag", 64'(iop_post_host), 1);
        chk("R3 host addr", 64'(iop_post_addr), 64'h00AB_CDE0);
        iop_post_pop = 1; step(); iop_post_pop = 0;
        cur_req = "R6";
        for (int i = 0; i < DEPTH + 2; i++) hwr(8'h40, 32'h10 + i);
        chk("R6 head kept", 64'(iop_post_data), 64'h10);
        repeat (DEPTH + 1) begin iop_post_pop = 1; step(); end
        iop_post_pop = 0;
        chk("R6 drained", 64'(iop_post_valid), 0);

        // R4 + R7 + R8: completions, status, mask
        cur_req = "R4";
        iop_cpl_push = 1; iop_cpl_data = 32'hA1; step();
        iop_cpl_data = 32'hA2; step(); iop_cpl_push = 0;
        chk("R8 masked", 64'(host_irq), 0);
        hwr(8'h34, 32'h0);
        chk("R8 unmasked irq", 64'(host_irq), 1);
        hrd(8'h44); chk("R4 cpl first", 64'(hst_rdata), 64'hA1);
        hrd(8'h44); chk("R4 cpl second", 64'(hst_rdata), 64'hA2);
        hrd(8'h44); chk("R4 cpl empty", 64'(hst_rdata), 64'hFFFF_FFFF);
        cur_req = "R7";
        hrd(8'h30); chk("R7 ostat", 64'(hst_rdata), 64'h8);
        iop_cpl_push = 1; iop_cpl_data = 32'hA3;
        hwr(8'h30, 32'hF); iop_cpl_push = 0;
        chk("R7 set wins", 64'(host_irq), 1);
        hwr(8'h30, 32'h8);
        chk("R7 cleared", 64'(host_irq), 0);
        iop_omsg_we = 2'b10; iop_omsg_wdata = 32'h55; step(); iop_omsg_we = 0;
        hrd(8'h30); chk("R7 omsg1 bit", 64'(hst_rdata), 64'h2);
        hrd(8'h1C); chk("R1 omsg1 read", 64'(hst_rdata), 64'h55);
        hwr(8'h30, 32'h2);
        cur_req = "R6";
        for (int i = 0; i < DEPTH + 1; i++) begin
            iop_cpl_push = 1; iop_cpl_data = 32'hB0 + i; step();
        end
        iop_cpl_push = 0;
        chk("R6 cpl full", 64'(iop_cpl_full), 1);
        hrd(8'h44); chk("R6 cpl kept", 64'(hst_rdata), 64'hA3);
        hwr(8'h34, 32'hF);
        chk("R8 remasked", 64'(host_irq), 0);

        // R5: returned list
        cur_req = "R5";
        hwr(8'h44, 32'h300);
        hwr(8'h44, 32'h340);
        chk("R5 ret head", 64'(iop_ret_data), 64'h300);
        iop_ret_pop = 1; step(); iop_ret_pop = 0;
        chk("R5 ret next", 64'(iop_ret_data), 64'h340);

        // R11: command echo
        cur_req = "R11";
        hwr(8'h10, 32'h77);
        iop_omsg_we = 2'b01; iop_omsg_wdata = 32'h76; step(); iop_omsg_we = 0;
        chk("R11 mismatch", 64'(hst_cmd_done), 0);
        iop_omsg_we = 2'b01; iop_omsg_wdata = 32'h77; step(); iop_omsg_we = 0;
        chk("R11 done", 64'(hst_cmd_done), 1);
        hwr(8'h10, 32'h78);
        chk("R11 rearm", 64'(hst_cmd_done), 0);

        repeat (3) step();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule